// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the address of each beat of a four-beat burst. When a burst opens, a load strobe captures the full address. The two lowest bits become the burst's start value, and the upper bits are held as they were captured. Each pulse on the advance input then steps the low bits to the next beat. The low bits wrap after the fourth beat and return to the start value.

Two orders are supported. In the linear order the low bits count up by one, modulo four. In the interleaved order the low bits are the start value XOR a private beat count that clears on load. The order select is captured together with the address, so one burst keeps one order from start to finish. Any level on the select other than a driven low picks the interleaved order, which makes interleaved the default when the select is left floating. Reset is asserted asynchronously and released on a clock edge, after two flops.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no load yet, addr_out is all zeros.
- R2: One clock after a cycle with load high, addr_out equals the addr_in value sampled in that cycle. The burst start value is addr_in[1:0].
- R3: When the order captured at load is linear (order_sel = 0), each advance adds one, modulo 4, to addr_out[1:0]. For example, a start of 01 gives 01, 10, 11, 00.
- R4: When the order captured at load is interleaved (order_sel = 1), addr_out[1:0] is the start value XOR the number of advances since load. A start of 01 gives 01, 00, 11, 10. A start of 10 gives 10, 11, 00, 01. A start of 11 gives 11, 10, 01, 00.
- R5: In either order, after four advances addr_out[1:0] is back at the start value.
- R6: addr_out above bit 1 keeps the value captured at load through any number of advances, whatever addr_in does without a load.
- R7: In a cycle with load and adv both low, addr_out does not change.
- R8: When load and adv are high in the same cycle, the load wins and addr_out shows the start value, not its successor.
- R9: A change of order_sel after load has no effect on the running burst. The new level applies only from the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load | input | 1 | Opens a burst and captures addr_in and order_sel |
| addr_in | input | ADDR_W | Burst start address |
| adv | input | 1 | Steps to the next beat |
| order_sel | input | 1 | 0 selects linear order; 1 or undriven selects interleaved |
| addr_out | output | ADDR_W | Current beat address |

## Verification
The bench builds the block with ADDR_W = 12 and the counter width left at 2. This gives ten upper bits, so the captured upper address can be a distinctive pattern that differs from a later addr_in. That makes a pass-through leak or an upper-bit bleed from the counter visible. With a 2-bit counter, all four start values in both orders fit in an eight-row table, and wrap-around is reached on the fourth advance of every row.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [CNT_W-1:0] start_in,
  input  order_e           order_in,
  output logic [CNT_W-1:0] start_q,
  output logic [CNT_W-1:0] beat_q,
  output order_e           order_q
);

  logic [CNT_W-1:0] start_d;
  logic [CNT_W-1:0] beat_d;
  order_e           order_d;
  logic             cnt_en;

  assign cnt_en = load | adv;

  always_comb begin
    start_d = start_q;
    beat_d  = beat_q;
    order_d = order_q;
    if (load) begin
      start_d = start_in;
      beat_d  = '0;
      order_d = order_in;
    end else if (adv) begin
      beat_d  = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
      order_q <= ORDER_INTERLEAVE;
    end else if (cnt_en) begin
      start_q <= start_d;
      beat_q  <= beat_d;
      order_q <= order_d;
    end
  end

  AST_BEAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat_q == '0)) else $error("beat not cleared on load"); // R2
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv) |=> (beat_q == $past(beat_q) + 1'b1)) else $error("beat step wrong"); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> ($stable(beat_q) && $stable(start_q))) else $error("idle drift"); // R7
  AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(order_q)) else $error("order changed mid-burst"); // R9

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] beat_cnt,
  input  order_e           order,
  output logic [CNT_W-1:0] low_addr
);

  logic [CNT_W-1:0] lin_addr;
  logic [CNT_W-1:0] il_addr;

  assign lin_addr = start_val + beat_cnt;

  for (genvar b = 0; b < CNT_W; b++) begin : g_il_bit
    assign il_addr[b] = start_val[b] ^ beat_cnt[b];
  end

  always_comb begin
    if (order == ORDER_LINEAR) low_addr = lin_addr;
    else                       low_addr = il_addr;
  end

  always_comb begin
    if (beat_cnt == '0)
      AST_FIRST_BEAT: assert (low_addr == start_val) else $error("first beat not start"); // R5
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              adv,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int UP_W = ADDR_W - CNT_W;

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [UP_W-1:0]  upper_q;
  logic [UP_W-1:0]  upper_d;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] beat_q;
  logic [CNT_W-1:0] low_addr;
  order_e           order_q;
  order_e           order_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Only a clean low asks for linear order; high or floating gives interleaved.
  assign order_req = (order_sel !== 1'b0) ? ORDER_INTERLEAVE : ORDER_LINEAR;

  always_comb begin
    upper_d = upper_q;
    if (load) upper_d = addr_in[ADDR_W-1:CNT_W];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  upper_q <= '0;
    else if (load)   upper_q <= upper_d;
  end

  burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (load),
    .adv      (adv),
    .start_in (addr_in[CNT_W-1:0]),
    .order_in (order_req),
    .start_q  (start_q),
    .beat_q   (beat_q),
    .order_q  (order_q)
  );

  burst_order_map #(.CNT_W(CNT_W)) u_map (
    .start_val (start_q),
    .beat_cnt  (beat_q),
    .order     (order_q),
    .low_addr  (low_addr)
  );

  assign addr_out = {upper_q, low_addr};

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_int_n)
    load |=> (addr_out == $past(addr_in))) else $error("load capture wrong"); // R2
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !load |=> $stable(addr_out[ADDR_W-1:CNT_W])) else $error("upper bits moved"); // R6
  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!load && !adv) |=> $stable(addr_out)) else $error("output drift"); // R7
  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!load && adv && order_q == ORDER_LINEAR) |=>
      (addr_out[CNT_W-1:0] == $past(addr_out[CNT_W-1:0]) + 1'b1)) else $error("linear step wrong"); // R3
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_int_n |-> (addr_out == '0)) else $error("not zero in reset"); // R1

endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              adv = 1'b0;
  logic              order_sel = 1'b1;
  logic [ADDR_W-1:0] addr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(2)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .addr_in(addr_in),
    .adv(adv), .order_sel(order_sel), .addr_out(addr_out)
  );

  // {order, start, beat0, beat1, beat2, beat3}
  localparam logic [10:0] VEC [8] = '{
    11'b0_00_00_01_10_11,
    11'b0_01_01_10_11_00,
    11'b0_10_10_11_00_01,
    11'b0_11_11_00_01_10,
    11'b1_00_00_01_10_11,
    11'b1_01_01_00_11_10,
    11'b1_10_10_11_00_01,
    11'b1_11_11_10_01_00
  };

  task automatic check(string tag, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample just after it.
  task automatic cycle(logic ld, logic [ADDR_W-1:0] a, logic av, logic os);
    @(negedge clk);
    load = ld; addr_in = a; adv = av; order_sel = os;
    @(posedge clk);
    #2;
    load = 1'b0; adv = 1'b0;
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] base;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", addr_out, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2 check("R1 after release", addr_out, '0);

    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      logic [ADDR_W-1:0] up;
      v  = VEC[i];
      up = {10'(10'h2A5 ^ (i * 37)), 2'b00};
      cycle(1'b1, up | {10'b0, v[9:8]}, 1'b0, v[10]);
      check("R2 load", addr_out, up | {10'b0, v[7:6]});
      for (int b = 1; b < 4; b++) begin
        cycle(1'b0, ~up, 1'b1, ~v[10]);
        if (v[10]) check("R4 interleaved beat", addr_out, up | {10'b0, v[7-2*b -: 2]});
        else       check("R3 linear beat", addr_out, up | {10'b0, v[7-2*b -: 2]});
      end
      cycle(1'b0, ~up, 1'b1, v[10]);
      check("R5 wrap to start", addr_out, up | {10'b0, v[9:8]});
      check("R6 upper held", {addr_out[ADDR_W-1:2], 2'b00}, up);
    end

    // R7: idle cycles hold the output
    base = 12'hC35;
    cycle(1'b1, base, 1'b0, 1'b0);
    cycle(1'b0, 12'h000, 1'b1, 1'b0);
    cycle(1'b0, 12'hFFF, 1'b0, 1'b1);
    cycle(1'b0, 12'h3CA, 1'b0, 1'b0);
    check("R7 hold without adv", addr_out, 12'hC36);

    // R8: load beats adv in the same cycle
    cycle(1'b0, 12'h000, 1'b1, 1'b0);
    cycle(1'b1, 12'h5A6, 1'b1, 1'b0);
    check("R8 load over adv", addr_out, 12'h5A6);

    // R9: order change after load is ignored
    cycle(1'b1, 12'h871, 1'b0, 1'b1);
    cycle(1'b0, 12'h871, 1'b1, 1'b0);
    check("R9 order kept interleaved", addr_out, 12'h870);
    cycle(1'b1, 12'h871, 1'b0, 1'b0);
    cycle(1'b0, 12'h871, 1'b1, 1'b1);
    check("R9 order kept linear", addr_out, 12'h872);

    // R1: mid-burst reset returns output to zero
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1 async reset", addr_out, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2 check("R1 after second release", addr_out, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule